// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral master that software drives through a small word-wide register bus. Software picks one of eight active-low select lines, chooses the clock polarity and phase, the bit order of each direction and an 8-bit or 16-bit word length, and then writes a word to the transmit register. The block shifts that word out on MOSI and collects the same number of bits from MISO. It then raises a completion flag that software polls, reads the received word, and clears before it starts the next word.

The serial clock rate comes from an external divider that supplies a one-cycle tick enable. Each tick moves SCK by one half period. The point at which MISO is captured can be pushed back by up to three core-clock cycles after the nominal edge. This leaves room for slow return paths at high clock rates. Select lines, serial clock and data out are all driven from flops, so a single control write moves the active select from one line to another with no glitch on the others.

Top module: `spi_rm_master`

## Requirements
- R1: After reset, all eight select outputs are high, SCK and MOSI are low, the timing register reads 0x40 (delay 1), and the control, configuration, receive and cause registers read 0.
- R2: Control register (offset 0x00): bit 0 asserts a select and bits 4:2 hold the index 0..7. cs_no[index] is low only when bit 0 is set. At most one select is low at a time, and a single write moves it from one line to another. Select outputs change only on a control write, and the register reads back as written in those bits.
- R3: Configuration register (offset 0x04): bit 11 is CPOL and bit 12 is CPHA. SCK idles at CPOL. With CPHA=0 the first bit is on MOSI before the first edge and MISO is sampled on leading edges. With CPHA=1 data is driven on leading edges and sampled on trailing edges.
- R4: Configuration bit 13 sends the transmit word least-significant bit first. When it is clear, the word is sent most-significant bit first.
- R5: Configuration bit 14 places the first received bit in bit 0 of the receive word. When it is clear, the first received bit is placed in the most-significant bit of the word.
- R6: Configuration bit 5 selects 16-bit words; otherwise words are 8 bits. A word makes exactly twice its bit count of SCK edges. The receive register (offset 0x0C) holds the last word, zero-extended.
- R7: Writing the transmit register (offset 0x08) starts one word exchange, and a value of zero is a valid dummy word. A transmit write while a word is in flight is ignored.
- R8: The cause register (offset 0x10) reads 1 once a word completes, and any write to it clears it to 0.
- R9: Timing register (offset 0x18) bits 7:6 give a delay d in 0..3. MISO is captured d core-clock cycles after the nominal sampling edge.
- R10: Configuration and timing writes made while a word is in flight do not change that word's timing, order, length or result.
- R11: SCK changes only on a tick or a configuration write. MOSI holds its last bit between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-period enable from the clock divider |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 8 | Active-low select lines |

## Verification
The bench's slave model can hold a wrong MISO bit for a set number of cycles after each SCK edge. When that lag exceeds the programmed delay, a design that ignores the timing field, or captures one cycle early or late, returns an inverted or wrong word where an exact one is expected. Every mode and bit-order combination is compared against words the bench computes itself. Errors it targets:
- A swapped sampling edge returns shifted data.
- A bit-order slip reverses the word.
- A word length taken from the live register instead of a snapshot breaks the transfer that is in flight.
- A select decode from the wrong field bits leaves two lines low.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_CFG   = 'h04;
  localparam int unsigned OFS_TX    = 'h08;
  localparam int unsigned OFS_RX    = 'h0C;
  localparam int unsigned OFS_CAUSE = 'h10;
  localparam int unsigned OFS_TIM   = 'h18;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IDX_LSB  = 2;
  localparam int CFG_WIDE_BIT  = 5;
  localparam int CFG_CPOL_BIT  = 11;
  localparam int CFG_CPHA_BIT  = 12;
  localparam int CFG_TXLSB_BIT = 13;
  localparam int CFG_RXLSB_BIT = 14;
  localparam int TIM_DLY_LSB   = 6;
  localparam logic [1:0] TIM_DLY_RST = 2'd1;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       tx_lsb;
    logic       rx_lsb;
    logic       wide;
    logic [1:0] dly;
  } spi_cfg_t;
endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int NUM_CS = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output spi_cfg_t          cfg_o,
  output logic              start_o,
  output logic [WORD_W-1:0] tx_word_o,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [NUM_CS-1:0] cs_no
);
  localparam int IDX_W = $clog2(NUM_CS);

  logic             cs_en_q;
  logic [IDX_W-1:0] cs_idx_q;
  logic             cause_q;
  spi_cfg_t         cfg_q;
  logic [NUM_CS-1:0] cs_q;

  logic wr_ctrl, wr_cfg, wr_tim, wr_cause;
  assign wr_ctrl  = we_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_cfg   = we_i && (addr_i == ADDR_W'(OFS_CFG));
  assign wr_tim   = we_i && (addr_i == ADDR_W'(OFS_TIM));
  assign wr_cause = we_i && (addr_i == ADDR_W'(OFS_CAUSE));
  assign start_o  = we_i && (addr_i == ADDR_W'(OFS_TX));
  assign tx_word_o = wdata_i[WORD_W-1:0];
  assign cfg_o = cfg_q;
  assign cs_no = cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_en_q  <= 1'b0;
      cs_idx_q <= '0;
      cause_q  <= 1'b0;
      cfg_q    <= '{cpol: 1'b0, cpha: 1'b0, tx_lsb: 1'b0, rx_lsb: 1'b0,
                    wide: 1'b0, dly: TIM_DLY_RST};
    end else begin
      if (wr_ctrl) begin
        cs_en_q  <= wdata_i[CTRL_EN_BIT];
        cs_idx_q <= wdata_i[CTRL_IDX_LSB +: IDX_W];
      end
      if (wr_cfg) begin
        cfg_q.cpol   <= wdata_i[CFG_CPOL_BIT];
        cfg_q.cpha   <= wdata_i[CFG_CPHA_BIT];
        cfg_q.tx_lsb <= wdata_i[CFG_TXLSB_BIT];
        cfg_q.rx_lsb <= wdata_i[CFG_RXLSB_BIT];
        cfg_q.wide   <= wdata_i[CFG_WIDE_BIT];
      end
      if (wr_tim) cfg_q.dly <= wdata_i[TIM_DLY_LSB +: 2];
      if (done_i)        cause_q <= 1'b1;
      else if (wr_cause) cause_q <= 1'b0;
    end
  end

  // one flop per select line: a control write updates all of them on one edge
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cs_q[i] <= 1'b1;
      else if (wr_ctrl) cs_q[i] <= !(wdata_i[CTRL_EN_BIT] &&
                                     (wdata_i[CTRL_IDX_LSB +: IDX_W] == IDX_W'(i)));
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_CTRL): begin
        rdata_o[CTRL_EN_BIT] = cs_en_q;
        rdata_o[CTRL_IDX_LSB +: IDX_W] = cs_idx_q;
      end
      ADDR_W'(OFS_CFG): begin
        rdata_o[CFG_CPOL_BIT]  = cfg_q.cpol;
        rdata_o[CFG_CPHA_BIT]  = cfg_q.cpha;
        rdata_o[CFG_TXLSB_BIT] = cfg_q.tx_lsb;
        rdata_o[CFG_RXLSB_BIT] = cfg_q.rx_lsb;
        rdata_o[CFG_WIDE_BIT]  = cfg_q.wide;
      end
      ADDR_W'(OFS_RX):    rdata_o[WORD_W-1:0] = rx_word_i;
      ADDR_W'(OFS_CAUSE): rdata_o[0] = cause_q;
      ADDR_W'(OFS_TIM):   rdata_o[TIM_DLY_LSB +: 2] = cfg_q.dly;
      default:            rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = &{1'b0, wdata_i};
endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift
  import spi_rm_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  spi_cfg_t          cfg_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam int CNT_W = BIT_W + 1;
  localparam int POS_W = $clog2(WORD_W);

  function automatic logic [POS_W-1:0] bit_pos(input logic [BIT_W-1:0] k,
                                               input logic lsb, input logic wide);
    logic [BIT_W-1:0] n, r;
    n = wide ? BIT_W'(WORD_W) : BIT_W'(WORD_W / 2);
    r = lsb ? k : (n - k - BIT_W'(1));
    return r[POS_W-1:0];
  endfunction

  logic              busy_q, lvl_q, mosi_q, pend_q, done_q;
  logic [CNT_W-1:0]  edge_q;
  logic [BIT_W-1:0]  ntx_q, nrx_q;
  logic [1:0]        dcnt_q;
  spi_cfg_t          snap_q;
  logic [WORD_W-1:0] tx_q, acc_q, rx_q;

  logic [BIT_W-1:0] n_bits;
  logic [CNT_W-1:0] n_edges;
  logic edge_ok, samp_edge, drv_edge, cap_now, finish;

  assign n_bits    = snap_q.wide ? BIT_W'(WORD_W) : BIT_W'(WORD_W / 2);
  assign n_edges   = {n_bits, 1'b0};
  assign edge_ok   = busy_q && tick_i && (edge_q != n_edges);
  // even edges lead; CPHA=0 samples on leading edges, CPHA=1 on trailing
  assign samp_edge = edge_ok && (edge_q[0] == snap_q.cpha);
  assign drv_edge  = edge_ok && !samp_edge;
  assign cap_now   = (samp_edge && (snap_q.dly == 2'd0)) || (pend_q && (dcnt_q == 2'd1));
  assign finish    = busy_q && (edge_q == n_edges) && (nrx_q == n_bits) && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; lvl_q <= 1'b0; mosi_q <= 1'b0; pend_q <= 1'b0; done_q <= 1'b0;
      edge_q <= '0; ntx_q <= '0; nrx_q <= '0; dcnt_q <= '0;
      snap_q <= '0; tx_q <= '0; acc_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        lvl_q  <= 1'b0;
        edge_q <= '0;
        nrx_q  <= '0;
        pend_q <= 1'b0;
        snap_q <= cfg_i;
        tx_q   <= tx_word_i;
        acc_q  <= '0;
        if (!cfg_i.cpha) begin
          mosi_q <= tx_word_i[bit_pos('0, cfg_i.tx_lsb, cfg_i.wide)];
          ntx_q  <= BIT_W'(1);
        end else begin
          ntx_q  <= '0;
        end
      end else if (busy_q) begin
        if (edge_ok) begin
          lvl_q  <= ~lvl_q;
          edge_q <= edge_q + CNT_W'(1);
        end
        if (drv_edge && (ntx_q < n_bits)) begin
          mosi_q <= tx_q[bit_pos(ntx_q, snap_q.tx_lsb, snap_q.wide)];
          ntx_q  <= ntx_q + BIT_W'(1);
        end
        if (samp_edge && (snap_q.dly != 2'd0)) begin
          pend_q <= 1'b1;
          dcnt_q <= snap_q.dly;
        end else if (pend_q) begin
          if (dcnt_q == 2'd1) pend_q <= 1'b0;
          dcnt_q <= dcnt_q - 2'd1;
        end
        if (cap_now) begin
          acc_q[bit_pos(nrx_q, snap_q.rx_lsb, snap_q.wide)] <= miso_i;
          nrx_q <= nrx_q + BIT_W'(1);
        end
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= acc_q;
        end
      end
    end
  end

  assign sck_o     = (busy_q ? snap_q.cpol : cfg_i.cpol) ^ lvl_q;
  assign mosi_o    = mosi_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_word_o = rx_q;
endmodule

// File: rtl/spi_rm_master.sv
module spi_rm_master
  import spi_rm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int NUM_CS = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no
);
  spi_cfg_t          cfg;
  logic              start, done, busy;
  logic [WORD_W-1:0] tx_word, rx_word;

  spi_rm_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WORD_W(WORD_W)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cfg_o(cfg), .start_o(start), .tx_word_o(tx_word),
    .done_i(done), .rx_word_i(rx_word), .cs_no
  );

  spi_rm_shift #(.WORD_W(WORD_W)) u_eng (
    .clk_i, .rst_ni, .tick_i, .start_i(start), .tx_word_i(tx_word),
    .cfg_i(cfg), .miso_i, .sck_o, .mosi_o, .busy_o(busy), .done_o(done),
    .rx_word_o(rx_word)
  );

  logic unused_busy;
  assign unused_busy = busy;
endmodule

// File: rtl/spi_rm_master_chk.sv
module spi_rm_master_chk #(
  parameter int ADDR_W = 5,
  parameter int NUM_CS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              sck_o,
  input logic              mosi_o,
  input logic [NUM_CS-1:0] cs_no,
  input logic              start,
  input logic              busy,
  input logic              done
);
  a_r2_one_select_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);

  a_r2_select_needs_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == ADDR_W'(spi_rm_pkg::OFS_CTRL))) |=> $stable(cs_no));

  a_r11_sck_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !we_i) |=> $stable(sck_o));

  a_r11_mosi_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !we_i) |=> $stable(mosi_o));

  a_r7_start_launches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !busy) |=> busy);

  a_r8_done_ends_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (!busy && $past(busy)));
endmodule

bind spi_rm_master spi_rm_master_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_chk (
  .clk_i, .rst_ni, .tick_i, .we_i, .addr_i, .sck_o, .mosi_o, .cs_no,
  .start, .busy, .done
);

// File: tb/sim_spi_rm_master.sv
module sim_spi_rm_master;
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TX = 5'h08,
                         A_RX = 5'h0C, A_CAUSE = 5'h10, A_TIM = 5'h18;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0, miso = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, mosi;
  logic [7:0]  cs_n;

  always #5 clk = ~clk;

  spi_rm_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // slave model state
  bit armed = 0, cpha_m = 0;
  int ec = 0, cyc_since = 9, lag = 0, nb_m = 8, ncap = 0, tcnt = 0;
  logic [15:0] sw = '0, mcap = '0;
  logic sck_prev = 1'b0;

  always @(negedge clk) begin
    int j, e;
    tick = (tcnt == 3);
    tcnt = (tcnt + 1) % 4;
    if (armed) begin
      if (sck !== sck_prev) begin
        ec++;
        cyc_since = 1;
        e = ec - 1;
        if (((e % 2) == 0) == (cpha_m == 0)) begin
          if (ncap < 16) mcap[ncap] = mosi;
          ncap++;
        end
      end else cyc_since++;
    end
    sck_prev = sck;
    j = cpha_m ? ((ec == 0) ? 0 : (ec - 1) / 2) : ec / 2;
    if (j >= nb_m) j = nb_m - 1;
    miso = (cyc_since >= lag) ? sw[nb_m-1-j] : ~sw[nb_m-1-j];
  end

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [15:0] exp_rx(logic [15:0] s, bit rxl, bit wide, bit inv);
    int nb = wide ? 16 : 8;
    logic [15:0] r = '0;
    for (int k = 0; k < nb; k++) begin
      if (rxl) r[k] = s[nb-1-k] ^ inv;
      else     r[nb-1-k] = s[nb-1-k] ^ inv;
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_mosi(logic [15:0] t, bit txl, bit wide);
    int nb = wide ? 16 : 8;
    logic [15:0] m = '0;
    for (int k = 0; k < nb; k++) m[k] = txl ? t[k] : t[nb-1-k];
    return m;
  endfunction

  task automatic run_word(input bit cpol, cpha, txl, rxl, wide, input int d, lg,
                          input logic [15:0] tx, swv, input bit midcfg, midtx);
    logic [31:0] cfg, r;
    logic [15:0] em, er;
    int nb = wide ? 16 : 8;
    bit inv = (d != 0) && (lg > d);
    logic [7:0] cs_before;
    cfg = (32'(cpol) << 11) | (32'(cpha) << 12) | (32'(txl) << 13) |
          (32'(rxl) << 14) | (32'(wide) << 5);
    bus_wr(A_CFG, cfg);
    bus_wr(A_TIM, 32'(d) << 6);
    bus_wr(A_CAUSE, 0);
    cs_before = cs_n;
    @(negedge clk);
    ec = 0; ncap = 0; mcap = '0; cyc_since = 9; lag = lg; sw = swv;
    cpha_m = cpha; nb_m = nb; armed = 1;
    we = 1'b1; addr = A_TX; wdata = 32'(tx);
    @(negedge clk);
    we = 1'b0;
    if (midcfg) begin
      repeat (20) @(negedge clk);
      bus_wr(A_CFG, cfg ^ 32'h7020);           // R10: flip CPHA, both orders, width
      bus_wr(A_TIM, 32'((d + 1) % 4) << 6);    // R10: change delay mid word
    end
    if (midtx) begin
      repeat (10) @(negedge clk);
      bus_wr(A_TX, 32'(~tx));                  // R7: ignored while busy
    end
    r = 0;
    for (int i = 0; i < 3000; i++) begin
      bus_rd(A_CAUSE, r);
      if (r[0]) break;
    end
    armed = 0;
    chk(r == 32'd1, "R8 cause after word", r, 1);
    if (midcfg) begin
      bus_wr(A_CFG, cfg);
      bus_wr(A_TIM, 32'(d) << 6);
    end
    bus_rd(A_RX, r);
    er = exp_rx(swv, rxl, wide, inv);
    chk(r == 32'(er), inv ? "R9 late slave seen inverted" :
                      (rxl ? "R5 rx lsb-first word" : "R5 R6 rx word"), r, 32'(er));
    em = exp_mosi(tx, txl, wide);
    chk((ncap == nb) && (mcap == em), txl ? "R4 mosi lsb-first" : "R4 R7 mosi msb-first",
        {16'(ncap), mcap}, {16'(nb), em});
    chk(ec == 2 * nb, wide ? "R6 16-bit edge count" : "R6 8-bit edge count", ec, 2 * nb);
    repeat (6) @(negedge clk);
    chk(sck === cpol, "R3 sck idles at cpol", sck, cpol);
    chk(mosi === em[nb-1], "R11 mosi holds last bit", mosi, em[nb-1]);
    chk(cs_n == cs_before, "R2 selects steady over word", cs_n, cs_before);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(cs_n == 8'hFF, "R1 selects high", cs_n, 8'hFF);
    chk({sck, mosi} == 2'b00, "R1 sck mosi low", {sck, mosi}, 0);
    bus_rd(A_TIM, r);   chk(r == 32'h40, "R1 timing default", r, 32'h40);
    bus_rd(A_CTRL, r);  chk(r == 0, "R1 ctrl zero", r, 0);
    bus_rd(A_CFG, r);   chk(r == 0, "R1 cfg zero", r, 0);
    bus_rd(A_RX, r);    chk(r == 0, "R1 rx zero", r, 0);
    bus_rd(A_CAUSE, r); chk(r == 0, "R1 cause zero", r, 0);
    // R2 select control
    bus_wr(A_CTRL, 32'h0D);
    chk(cs_n == 8'hF7, "R2 select 3 low", cs_n, 8'hF7);
    bus_wr(A_CTRL, 32'h19);
    chk(cs_n == 8'hBF, "R2 move to select 6", cs_n, 8'hBF);
    bus_wr(A_CTRL, 32'h18);
    chk(cs_n == 8'hFF, "R2 deassert", cs_n, 8'hFF);
    bus_rd(A_CTRL, r); chk(r == 32'h18, "R2 ctrl readback", r, 32'h18);
    bus_wr(A_CTRL, 32'h09);
    chk(cs_n == 8'hFB, "R2 select 2 low", cs_n, 8'hFB);
    // directed modes
    run_word(0, 0, 0, 0, 0, 1, 0, 16'h00A5, 16'h003C, 0, 0);
    run_word(1, 1, 0, 0, 0, 2, 2, 16'h0081, 16'h00C3, 0, 0);
    run_word(0, 1, 1, 1, 1, 0, 0, 16'hBEEF, 16'h1234, 0, 0);
    run_word(1, 0, 1, 0, 1, 3, 3, 16'h8001, 16'hF00D, 0, 0);
    run_word(0, 0, 0, 0, 0, 0, 0, 16'h0000, 16'h005A, 0, 0);  // R7 dummy word
    // R9 late-slave cases: delay shorter than lag must read inverted bits
    run_word(0, 0, 0, 0, 0, 1, 2, 16'h0033, 16'h0096, 0, 0);
    run_word(1, 1, 0, 1, 1, 2, 3, 16'h1357, 16'hACE1, 0, 0);
    run_word(0, 1, 0, 0, 1, 3, 3, 16'h2468, 16'h9BDF, 0, 0);
    // R10 and R7 mid-word writes
    run_word(0, 1, 0, 1, 0, 1, 1, 16'h005C, 16'h00E7, 1, 0);
    run_word(1, 0, 1, 0, 1, 2, 2, 16'h7E81, 16'h0FF0, 0, 1);
    // R8 clear
    bus_wr(A_CAUSE, 0);
    bus_rd(A_CAUSE, r); chk(r == 0, "R8 cause cleared", r, 0);
    // random mix
    for (int i = 0; i < 40; i++) begin
      int d = $urandom_range(0, 3);
      int lg = (d == 0) ? 0 : $urandom_range(0, 3);
      logic [31:0] v1 = $urandom(), v2 = $urandom();
      run_word(v1[0], v1[1], v1[2], v1[3], v1[4], d, lg, v2[15:0], v2[31:16],
               v1[5] && v1[6], 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule